// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

The block drives three motor phases. Each phase has a positive and a negative output. Two linked up/down counters produce a centre-aligned carrier. The second counter runs a triangle between zero and the half-carrier value. The first counter runs the same triangle shifted up by the dead time, so it turns at the upper limit (half carrier plus dead time) and at the dead-time value. Each phase's positive output is driven from the first counter. Its negative output is driven from the second counter. Because the counters are offset, the pair of outputs is separated by exactly the dead time at each switching edge, and no per-edge delay timer is needed.

Software configures the block through a simple write port while both counters are stopped. It sets the dead time, the limits, the counter start values, the three duty values, the per-pin enables and the polarity. One write of the run bit then starts both counters together. Duty values and the limit/half-carrier pair each have a shadow register with its own enable. A shadow copy reaches the working register only at a carrier turning point. A toggle output can mark every carrier peak and trough.

Top module: `cpwm3_gen`

## Requirements
- R1: After reset, every PWM pin and the toggle output are 0, both counters read 0, and the counters are stopped.
- R2: Writing 1 to bit 0 of address 0 starts both counters on the same edge. While running, counter B steps by one per clock: up from 0 to the half-carrier value (address 4), then down to 0. Counter A steps up to the limit (address 2), then down to the dead time (address 1). The start values come from addresses 13 (A) and 14 (B), and loading either counter sets its direction to up.
- R3: While running, writes to addresses 1, 2, 4, 6 to 8 and 12 to 14 are ignored.
- R4: For phase i (0 to 2, duty at address 6+i), the positive output is active on the clock after counter A is at or below the duty. The negative output is active on the clock after counter B is above the duty. Both are inactive while stopped.
- R5: With the dead time programmed as the counter offset, a phase's two outputs are never active together, and each output turns on at least the dead time in clocks after its complement turned off.
- R6: Over one carrier period of twice the half-carrier value, each output is active for exactly the number of counter B values that satisfy its compare condition.
- R7: With bit 2 of address 0 set, a write to a duty shadow (address 9+i) reaches the working duty only at a peak (counter B reaches the half-carrier value while counting up) or a trough (counter B reaches 0 while counting down). With the bit clear, the write updates both registers at once.
- R8: With bit 1 of address 0 set, the limit shadow (address 3) and half-carrier shadow (address 5) move to the working registers only at a trough. With the bit clear, writes to those addresses update the working registers at once.
- R9: Bit 4 of address 0 inverts the three positive pins and bit 5 inverts the three negative pins. An inverted pin reads 1 when inactive.
- R10: Address 12 holds six enables. Bits 0 to 2 enable the positive pins of phases 0 to 2 and bits 3 to 5 the negative pins. A disabled pin stays at its inactive level.
- R11: With bit 3 of address 0 set, the toggle output inverts on the clock after each peak or trough. With the bit clear, it is held at 0.
- R12: Clearing the run bit freezes both counters and drives every output to its inactive level on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address |
| wr_data | input | W | Register write data |
| pwm_p | output | 3 | Positive-phase outputs, phases 0 to 2 |
| pwm_n | output | 3 | Negative-phase outputs, phases 0 to 2 |
| tog_o | output | 1 | Carrier-synchronised toggle output |
| cnt_a_o | output | W | Counter A value |
| cnt_b_o | output | W | Counter B value |

## Verification
The dead-time and duty checks use three different duty values against one carrier. Low, middle and high compare points each give their own active counts for the positive and negative outputs, so a misplaced comparison or offset shows up in the count. Mid-run shadow writes, with buffering on and off, separate transfer at a turning point from immediate update. A half-carrier change through the shadow shows whether the new period starts only at a trough. Polarity, enable and stop patterns confirm that an inactive pin holds its inactive level, and that locked writes made while running leave the counting unchanged.

// File: rtl/cpwm3_gen.sv
module cpwm3_gen #(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  output logic [2:0]    pwm_p,
  output logic [2:0]    pwm_n,
  output logic          tog_o,
  output logic [W-1:0]  cnt_a_o,
  output logic [W-1:0]  cnt_b_o
);
  localparam int NPH = 3;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_DT   = AW'(1);
  localparam logic [AW-1:0] A_LIM  = AW'(2);
  localparam logic [AW-1:0] A_LIMB = AW'(3);
  localparam logic [AW-1:0] A_HC   = AW'(4);
  localparam logic [AW-1:0] A_HCB  = AW'(5);
  localparam int            A_DUTY = 6;
  localparam int            A_DBUF = 9;
  localparam logic [AW-1:0] A_OE   = AW'(12);
  localparam logic [AW-1:0] A_CA   = AW'(13);
  localparam logic [AW-1:0] A_CB   = AW'(14);

  logic           run, lbuf, dbuf, tog_en, pinv, ninv;
  logic [W-1:0]   dt_r, lim_r, lim_b, hc_r, hc_b;
  logic [W-1:0]   cnt_a, cnt_b;
  logic           up_a, up_b;
  logic [W-1:0]   duty_r [NPH];
  logic [W-1:0]   duty_b [NPH];
  logic [2*NPH-1:0] oe_r;
  logic [NPH-1:0] pos_raw, neg_raw, pos_q, neg_q;
  logic           tog_q;

  wire wr_ctrl = wr_en && (wr_addr == A_CTRL);
  wire cfg_wr  = wr_en && !run;
  wire peak    = run && up_b && (cnt_b >= hc_r);
  wire trough  = run && !up_b && (cnt_b == '0);
  wire turn    = peak || trough;

  // counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_a <= '0;
      cnt_b <= '0;
      up_a  <= 1'b1;
      up_b  <= 1'b1;
    end else if (run) begin
      if (up_a) begin
        if (cnt_a >= lim_r) begin
          cnt_a <= cnt_a - 1'b1;
          up_a  <= 1'b0;
        end else begin
          cnt_a <= cnt_a + 1'b1;
        end
      end else begin
        if (cnt_a <= dt_r) begin
          cnt_a <= cnt_a + 1'b1;
          up_a  <= 1'b1;
        end else begin
          cnt_a <= cnt_a - 1'b1;
        end
      end
      if (up_b) begin
        if (cnt_b >= hc_r) begin
          cnt_b <= cnt_b - 1'b1;
          up_b  <= 1'b0;
        end else begin
          cnt_b <= cnt_b + 1'b1;
        end
      end else begin
        if (cnt_b == '0) begin
          cnt_b <= cnt_b + 1'b1;
          up_b  <= 1'b1;
        end else begin
          cnt_b <= cnt_b - 1'b1;
        end
      end
    end else begin
      if (wr_en && wr_addr == A_CA) begin
        cnt_a <= wr_data;
        up_a  <= 1'b1;
      end
      if (wr_en && wr_addr == A_CB) begin
        cnt_b <= wr_data;
        up_b  <= 1'b1;
      end
    end
  end

  // control and timing registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      lbuf   <= 1'b0;
      dbuf   <= 1'b0;
      tog_en <= 1'b0;
      pinv   <= 1'b0;
      ninv   <= 1'b0;
      dt_r   <= '0;
      lim_r  <= '0;
      lim_b  <= '0;
      hc_r   <= '0;
      hc_b   <= '0;
      oe_r   <= '0;
    end else begin
      if (wr_ctrl) begin
        run    <= wr_data[0];
        lbuf   <= wr_data[1];
        dbuf   <= wr_data[2];
        tog_en <= wr_data[3];
        pinv   <= wr_data[4];
        ninv   <= wr_data[5];
      end
      if (cfg_wr && wr_addr == A_DT) dt_r <= wr_data;
      if (cfg_wr && wr_addr == A_LIM) lim_r <= wr_data;
      if (cfg_wr && wr_addr == A_HC) hc_r <= wr_data;
      if (cfg_wr && wr_addr == A_OE) oe_r <= wr_data[2*NPH-1:0];
      if (lbuf && trough) begin
        lim_r <= lim_b;
        hc_r  <= hc_b;
      end
      if (wr_en && wr_addr == A_LIMB) begin
        lim_b <= wr_data;
        if (!lbuf) lim_r <= wr_data;
      end
      if (wr_en && wr_addr == A_HCB) begin
        hc_b <= wr_data;
        if (!lbuf) hc_r <= wr_data;
      end
    end
  end

  // duty compare registers and shadows
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPH; i++) begin
        duty_r[i] <= '0;
        duty_b[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NPH; i++) begin
        if (cfg_wr && wr_addr == AW'(A_DUTY + i)) duty_r[i] <= wr_data;
        if (dbuf && turn) duty_r[i] <= duty_b[i];
        if (wr_en && wr_addr == AW'(A_DBUF + i)) begin
          duty_b[i] <= wr_data;
          if (!dbuf) duty_r[i] <= wr_data;
        end
      end
    end
  end

  // compare and output stage
  always_comb begin
    for (int i = 0; i < NPH; i++) begin
      pos_raw[i] = run && (cnt_a <= duty_r[i]);
      neg_raw[i] = run && (cnt_b > duty_r[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      neg_q <= '0;
      tog_q <= 1'b0;
    end else begin
      pos_q <= pos_raw & oe_r[NPH-1:0];
      neg_q <= neg_raw & oe_r[2*NPH-1:NPH];
      tog_q <= tog_en ? (tog_q ^ turn) : 1'b0;
    end
  end

  assign pwm_p   = pos_q ^ {NPH{pinv}};
  assign pwm_n   = neg_q ^ {NPH{ninv}};
  assign tog_o   = tog_q;
  assign cnt_a_o = cnt_a;
  assign cnt_b_o = cnt_b;

  p_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && up_b && cnt_b < hc_r) |=> (cnt_b == $past(cnt_b) + W'(1)));

  p_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wr_en && wr_addr == A_DT) |=> $stable(dt_r));

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_a >= cnt_b) |=> ((pos_q & neg_q) == '0));

  p_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && dbuf && !turn) |=> $stable(duty_r[0]));

  p_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pos_q & ~$past(oe_r[NPH-1:0])) == '0) &&
              ((neg_q & ~$past(oe_r[2*NPH-1:NPH])) == '0)));

  p_tog_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tog_en |=> !tog_q);

  p_frz_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(wr_en && wr_addr == A_CB)) |=> $stable(cnt_b));
endmodule

// File: tb/cpwm3_gen_bench.sv
`timescale 1ns/1ps
module cpwm3_gen_bench;
  localparam int W = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic [2:0]    pwm_p, pwm_n;
  logic          tog_o;
  logic [W-1:0]  cnt_a_o, cnt_b_o;

  cpwm3_gen #(.W(W), .AW(AW)) u_cpwm3_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_p(pwm_p), .pwm_n(pwm_n), .tog_o(tog_o),
    .cnt_a_o(cnt_a_o), .cnt_b_o(cnt_b_o));

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  string tag = "R1";
  bit cmp_on = 0, gap_on = 0;

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_run, m_lb, m_db, m_te, m_pi, m_ni;
  int m_dt, m_lim, m_limb, m_hc, m_hcb, m_a, m_b, m_upa, m_upb, m_oe, m_tog;
  int m_d[3], m_dsh[3];
  int m_pq[3], m_nq[3];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_lb = 0; m_db = 0; m_te = 0; m_pi = 0; m_ni = 0;
      m_dt = 0; m_lim = 0; m_limb = 0; m_hc = 0; m_hcb = 0;
      m_a = 0; m_b = 0; m_upa = 1; m_upb = 1; m_oe = 0; m_tog = 0;
      for (int i = 0; i < 3; i++) begin
        m_d[i] = 0; m_dsh[i] = 0; m_pq[i] = 0; m_nq[i] = 0;
      end
    end else begin
      int pk, tr, orun, odb, olb, a, d;
      pk = m_run && m_upb && m_b >= m_hc;
      tr = m_run && !m_upb && m_b == 0;
      for (int i = 0; i < 3; i++) begin
        m_pq[i] = m_run && m_a <= m_d[i] && ((m_oe >> i) & 1);
        m_nq[i] = m_run && m_b > m_d[i] && ((m_oe >> (i + 3)) & 1);
      end
      m_tog = m_te ? (m_tog ^ (pk || tr)) : 0;
      orun = m_run; odb = m_db; olb = m_lb;
      a = wr_en ? int'(wr_addr) : -1;
      d = int'(wr_data);
      if (orun) begin
        if (m_upa) begin
          if (m_a >= m_lim) begin m_a--; m_upa = 0; end else m_a++;
        end else begin
          if (m_a <= m_dt) begin m_a++; m_upa = 1; end else m_a--;
        end
        if (m_upb) begin
          if (m_b >= m_hc) begin m_b--; m_upb = 0; end else m_b++;
        end else begin
          if (m_b == 0) begin m_b++; m_upb = 1; end else m_b--;
        end
      end else begin
        if (a == 13) begin m_a = d; m_upa = 1; end
        if (a == 14) begin m_b = d; m_upb = 1; end
      end
      if (odb && (pk || tr)) for (int i = 0; i < 3; i++) m_d[i] = m_dsh[i];
      if (olb && tr) begin m_lim = m_limb; m_hc = m_hcb; end
      if (a == 0) begin
        m_run = d & 1; m_lb = (d >> 1) & 1; m_db = (d >> 2) & 1;
        m_te = (d >> 3) & 1; m_pi = (d >> 4) & 1; m_ni = (d >> 5) & 1;
      end
      if (!orun) begin
        if (a == 1) m_dt = d;
        if (a == 2) m_lim = d;
        if (a == 4) m_hc = d;
        if (a == 12) m_oe = d & 63;
        for (int i = 0; i < 3; i++) if (a == 6 + i) m_d[i] = d;
      end
      if (a == 3) begin m_limb = d; if (!olb) m_lim = d; end
      if (a == 5) begin m_hcb = d; if (!olb) m_hc = d; end
      for (int i = 0; i < 3; i++)
        if (a == 9 + i) begin m_dsh[i] = d; if (!odb) m_d[i] = d; end
    end
  end

  // per-cycle comparison and dead-time gap monitor
  int cyc = 0;
  int p_off[3], n_off[3];
  bit pv_p[3], pv_n[3];
  initial for (int i = 0; i < 3; i++) begin p_off[i] = -1000; n_off[i] = -1000; end

  always @(negedge clk) begin
    cyc++;
    if (rst_n && cmp_on) begin
      int ep, en;
      ep = 0; en = 0;
      for (int i = 0; i < 3; i++) begin
        ep |= (m_pq[i] ^ m_pi) << i;
        en |= (m_nq[i] ^ m_ni) << i;
      end
      chk({tag, " counter A"}, int'(cnt_a_o), m_a);
      chk({tag, " counter B"}, int'(cnt_b_o), m_b);
      chk({tag, " pos pins"}, int'(pwm_p), ep);
      chk({tag, " neg pins"}, int'(pwm_n), en);
      chk({tag, " toggle"}, int'(tog_o), m_tog);
    end
    if (rst_n && gap_on) begin
      for (int i = 0; i < 3; i++) begin
        chk("R5 exclusive", int'(pwm_p[i] & pwm_n[i]), 0);
        if (pv_p[i] && !pwm_p[i]) p_off[i] = cyc;
        if (pv_n[i] && !pwm_n[i]) n_off[i] = cyc;
        if (!pv_n[i] && pwm_n[i]) chk("R5 gap p->n", int'(cyc - p_off[i] >= m_dt), 1);
        if (!pv_p[i] && pwm_p[i]) chk("R5 gap n->p", int'(cyc - n_off[i] >= m_dt), 1);
      end
    end
    for (int i = 0; i < 3; i++) begin pv_p[i] = pwm_p[i]; pv_n[i] = pwm_n[i]; end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int tri_count(int hc, int lo, int hi);
    int c = 0;
    for (int v = 0; v <= hc; v++)
      if (v >= lo && v <= hi) c += (v == 0 || v == hc) ? 1 : 2;
    return c;
  endfunction

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int duty[3];
    duty[0] = 5; duty[1] = 10; duty[2] = 15;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk("R1 pos pins", int'(pwm_p), 0);
    chk("R1 neg pins", int'(pwm_n), 0);
    chk("R1 toggle", int'(tog_o), 0);
    chk("R1 counter A", int'(cnt_a_o), 0);
    chk("R1 counter B", int'(cnt_b_o), 0);
    cmp_on = 1;
    wr(1, 3); wr(2, 23); wr(4, 20); wr(3, 23); wr(5, 20);
    for (int i = 0; i < 3; i++) begin wr(6 + i, duty[i]); wr(9 + i, duty[i]); end
    wr(12, 63); wr(13, 3); wr(14, 0);
    idle(4);
    chk("R12 idle pins", int'(pwm_p | pwm_n), 0);
    // R2 joint start
    tag = "R2";
    gap_on = 1;
    wr(0, 1);
    idle(50);
    // R4 / R6 steady compare and duty over one period
    tag = "R4";
    begin
      int cp[3], cn[3];
      for (int i = 0; i < 3; i++) begin cp[i] = 0; cn[i] = 0; end
      repeat (40) begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin cp[i] += pwm_p[i]; cn[i] += pwm_n[i]; end
      end
      for (int i = 0; i < 3; i++) begin
        chk("R6 pos duty", cp[i], tri_count(20, 0, duty[i] - 3));
        chk("R6 neg duty", cn[i], tri_count(20, duty[i] + 1, 20));
      end
    end
    // R3 locked writes while running
    tag = "R3";
    wr(1, 9); wr(13, 0); wr(6, 0); wr(12, 0); wr(4, 7);
    idle(30);
    // R7 duty shadow
    tag = "R7";
    wr(0, 1 | 4);
    wr(9, 12);
    idle(50);
    wr(0, 1);
    wr(10, 8);
    idle(30);
    // R8 limit / half-carrier shadow
    tag = "R8";
    wr(0, 1 | 2);
    wr(5, 16); wr(3, 19);
    idle(90);
    wr(0, 1);
    // R11 toggle
    tag = "R11";
    wr(0, 1 | 8);
    idle(70);
    wr(0, 1);
    idle(10);
    // R9 polarity
    gap_on = 0;
    tag = "R9";
    wr(0, 1 | 16 | 32);
    idle(40);
    wr(0, 1);
    idle(5);
    // R12 stop
    tag = "R12";
    wr(0, 0);
    idle(20);
    chk("R12 stopped pins", int'(pwm_p | pwm_n), 0);
    // R10 per-pin enables
    tag = "R10";
    wr(12, 6'h15);
    wr(0, 1);
    idle(60);
    cmp_on = 0;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule